// File: doc/BRIEF.md
# Pulse-Multiplier Correction Counter

This block keeps a 16-bit count on the peripheral clock that chases a reference count arriving from outside. While the count sits strictly below the reference it steps up by one per clock, and each step leaves as a one-cycle pulse. Downstream timers use that pulse train as a frequency-multiplied clock. A clear-value input caps the count: once the count equals it, stepping halts even if the reference is still higher. While the count rests on the clear value, a clear request goes out to each of up to four downstream counters whose enable bit is set.

A rising edge on an asynchronous edge input starts a correction sequence, but only when an external reload counter reads zero. If the count already equals the clear value, the count jumps straight to 1. Otherwise the count runs forward one step per clock, pulsing on every step and ignoring the reference, until it reaches the clear value. It then jumps to 1. Further edges that arrive while this catch-up runs are discarded.

Top module: `pmul_corr_counter`

## Requirements
- R1: A synchronous reset sets the count to 0, leaves no correction sequence running, and holds the pulse output and every clear request low.
- R2: Outside a correction sequence, the count rises by exactly one on each clock edge where it is strictly below the reference and not equal to the clear value.
- R3: Every step of the count is marked by the pulse output being high for exactly the cycle in which the new count first appears. The pulse stays low in every other cycle.
- R4: Outside a correction sequence, a count that is equal to or greater than the reference stays unchanged and produces no pulse.
- R5: Outside a correction sequence, a count equal to the clear value stays unchanged and produces no pulse, whatever the reference holds.
- R6: Clear request bit i is high in exactly those cycles where the count equals the clear value and enable bit i was set at the clock edge that produced that count. Bit i serves downstream counter i.
- R7: The edge input passes through a two-flop synchronizer, and each low-to-high transition counts as one event. An event acts only when the reload count is zero; at any other time it has no effect on the count.
- R8: An acted-on event that finds the count equal to the clear value sets the count to 1 without a pulse.
- R9: An acted-on event that finds the count different from the clear value starts a catch-up. From then on the count steps by one per clock, with a pulse on each step, regardless of the reference and wrapping from all ones to zero. In the cycle after it reaches the clear value it becomes 1 without a pulse, and the catch-up ends.
- R10: Edge events during a running catch-up are discarded and do not extend or restart it.
- R11: After a correction sequence sets the count to 1, normal counting under R2, R4 and R5 resumes on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_cnt_i | input | CNT_W | External reference count the counter chases |
| clr_val_i | input | CNT_W | Clear value at which counting stops |
| rld_cnt_i | input | CNT_W | External reload counter value; zero arms the edge input |
| edge_i | input | 1 | Asynchronous edge input that starts a correction |
| clr_en_i | input | NUM_CLR | Per-downstream-counter clear enable bits |
| cnt_o | output | CNT_W | Current count |
| mclk_pulse_o | output | 1 | One-cycle pulse per count step (multiplied clock) |
| clr_req_o | output | NUM_CLR | Clear requests to downstream counters |

## Verification
The bench builds the block with CNT_W = 8 and keeps NUM_CLR = 4. At that width, a catch-up that starts above the clear value must wrap through all ones to zero, and this takes at most 256 steps. Long random runs can therefore cross the wrap point many times and rest on the clear value often. With all four clear lanes present, each enable bit is exercised on its own.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    // What the counter does on the coming clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_WRAP = 2'd2
    } pmul_act_e;

endpackage

// File: rtl/pmul_edge_sync.sv
module pmul_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk_i) begin
                if (rst_i) sync_q[0] <= 1'b0;
                else       sync_q[0] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i) begin
                if (rst_i) sync_q[s] <= 1'b0;
                else       sync_q[s] <= sync_q[s-1];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) last_q <= 1'b0;
        else       last_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pmul_cmp.sv
module pmul_cmp #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] ref_i,
    input  logic [CNT_W-1:0] clr_i,
    output logic             below_ref_o,
    output logic             at_clr_o
);
    assign below_ref_o = (cnt_i < ref_i);
    assign at_clr_o    = (cnt_i == clr_i);
endmodule

// File: rtl/pmul_clr_fanout.sv
module pmul_clr_fanout #(
    parameter int NUM_CLR = 4
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               hit_i,
    input  logic [NUM_CLR-1:0] en_i,
    output logic [NUM_CLR-1:0] req_o
);
    for (genvar i = 0; i < NUM_CLR; i++) begin : g_lane
        logic req_d;
        logic req_q;

        always_comb req_d = hit_i & en_i[i];

        always_ff @(posedge clk_i) begin
            if (rst_i) req_q <= 1'b0;
            else       req_q <= req_d;
        end

        assign req_o[i] = req_q;
    end
endmodule

// File: rtl/pmul_corr_counter.sv
module pmul_corr_counter #(
    parameter int CNT_W       = 16,
    parameter int NUM_CLR     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [CNT_W-1:0]   ref_cnt_i,
    input  logic [CNT_W-1:0]   clr_val_i,
    input  logic [CNT_W-1:0]   rld_cnt_i,
    input  logic               edge_i,
    input  logic [NUM_CLR-1:0] clr_en_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               mclk_pulse_o,
    output logic [NUM_CLR-1:0] clr_req_o
);
    import pmul_pkg::*;

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             pulse;
    } pmul_state_t;

    pmul_state_t st_d, st_q;
    pmul_act_e   act;

    logic edge_rise;
    logic cu_start;
    logic below_ref;
    logic at_clr;
    logic next_hit;
    logic busy_w;

    pmul_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (edge_i),
        .rise_o  (edge_rise)
    );

    pmul_cmp #(
        .CNT_W (CNT_W)
    ) u_cmp (
        .cnt_i       (st_q.cnt),
        .ref_i       (ref_cnt_i),
        .clr_i       (clr_val_i),
        .below_ref_o (below_ref),
        .at_clr_o    (at_clr)
    );

    assign cu_start = edge_rise & (rld_cnt_i == CNT_ZERO);

    always_comb begin
        st_d = st_q;
        act  = ACT_HOLD;
        if (st_q.busy) begin
            // catch-up in progress: new edges are not looked at
            if (at_clr) begin
                act       = ACT_WRAP;
                st_d.busy = 1'b0;
            end else begin
                act = ACT_STEP;
            end
        end else if (cu_start) begin
            if (at_clr) begin
                act = ACT_WRAP;
            end else begin
                act       = ACT_STEP;
                st_d.busy = 1'b1;
            end
        end else if (below_ref && !at_clr) begin
            act = ACT_STEP;
        end

        unique case (act)
            ACT_STEP: st_d.cnt = st_q.cnt + CNT_ONE;
            ACT_WRAP: st_d.cnt = CNT_ONE;
            default:  st_d.cnt = st_q.cnt;
        endcase
        st_d.pulse = (act == ACT_STEP);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign next_hit = (st_d.cnt == clr_val_i);

    pmul_clr_fanout #(
        .NUM_CLR (NUM_CLR)
    ) u_fan (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .hit_i (next_hit),
        .en_i  (clr_en_i),
        .req_o (clr_req_o)
    );

    assign busy_w       = st_q.busy;
    assign cnt_o        = st_q.cnt;
    assign mclk_pulse_o = st_q.pulse;
endmodule

// File: rtl/pmul_corr_counter_chk.sv
module pmul_corr_counter_chk #(
    parameter int CNT_W   = 16,
    parameter int NUM_CLR = 4
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic [CNT_W-1:0]   ref_cnt_i,
    input logic [CNT_W-1:0]   clr_val_i,
    input logic [NUM_CLR-1:0] clr_en_i,
    input logic [CNT_W-1:0]   cnt_o,
    input logic               mclk_pulse_o,
    input logic [NUM_CLR-1:0] clr_req_o,
    input logic               busy_i,
    input logic               start_i
);
    // R3
    pulse_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        mclk_pulse_o |-> cnt_o == CNT_W'($past(cnt_o) + 1'b1));

    // R3
    change_marked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_o != $past(cnt_o)) |-> (mclk_pulse_o || cnt_o == CNT_W'(1)));

    // R5
    no_step_at_clr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        mclk_pulse_o |-> $past(cnt_o) != $past(clr_val_i));

    // R4
    ref_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mclk_pulse_o && !$past(busy_i) && !$past(start_i))
            |-> $past(cnt_o) < $past(ref_cnt_i));

    // R6
    req_enabled_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_req_o & ~$past(clr_en_i)) == '0);

    // R6
    req_at_clr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_req_o != '0) |-> cnt_o == $past(clr_val_i));
endmodule

bind pmul_corr_counter pmul_corr_counter_chk #(
    .CNT_W   (CNT_W),
    .NUM_CLR (NUM_CLR)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .ref_cnt_i    (ref_cnt_i),
    .clr_val_i    (clr_val_i),
    .clr_en_i     (clr_en_i),
    .cnt_o        (cnt_o),
    .mclk_pulse_o (mclk_pulse_o),
    .clr_req_o    (clr_req_o),
    .busy_i       (busy_w),
    .start_i      (cu_start)
);

// File: tb/pmul_corr_counter_test.sv
`timescale 1ns/1ps
module pmul_corr_counter_test;
    localparam int W = 8;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] ref_cnt = '0;
    logic [W-1:0] clr_val = '0;
    logic [W-1:0] rld_cnt = '0;
    logic         edge_in = 1'b0;
    logic [N-1:0] en = '0;
    logic [W-1:0] cnt;
    logic         pulse;
    logic [N-1:0] req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    string tag = "R2";

    always #2.5 clk = ~clk;

    pmul_corr_counter #(.CNT_W(W), .NUM_CLR(N), .SYNC_STAGES(2)) uut (
        .clk_i        (clk),
        .rst_i        (rst),
        .ref_cnt_i    (ref_cnt),
        .clr_val_i    (clr_val),
        .rld_cnt_i    (rld_cnt),
        .edge_i       (edge_in),
        .clr_en_i     (en),
        .cnt_o        (cnt),
        .mclk_pulse_o (pulse),
        .clr_req_o    (req)
    );

    // Expected-value model built from the requirements.
    logic [W-1:0] m_cnt = '0;
    logic         m_busy = 1'b0, m_pulse = 1'b0;
    logic [N-1:0] m_req = '0;
    logic         m_s0 = 1'b0, m_s1 = 1'b0, m_last = 1'b0;

    function automatic logic [W-1:0] next_cnt(input logic [W-1:0] c, input logic step,
                                              input logic wrap);
        if (wrap)      return W'(1);
        else if (step) return W'(c + 1'b1);
        else           return c;
    endfunction

    always @(posedge clk) begin : model
        logic start, at, step, wrap, nbusy;
        logic [W-1:0] nc;
        if (rst) begin
            m_cnt <= '0; m_busy <= 1'b0; m_pulse <= 1'b0; m_req <= '0;
            m_s0 <= 1'b0; m_s1 <= 1'b0; m_last <= 1'b0;
        end else begin
            start = m_s1 & ~m_last & (rld_cnt == '0);
            at    = (m_cnt == clr_val);
            step  = 1'b0; wrap = 1'b0; nbusy = m_busy;
            if (m_busy) begin
                if (at) begin wrap = 1'b1; nbusy = 1'b0; end
                else step = 1'b1;
            end else if (start) begin
                if (at) wrap = 1'b1;
                else begin step = 1'b1; nbusy = 1'b1; end
            end else if (m_cnt < ref_cnt && !at) begin
                step = 1'b1;
            end
            nc = next_cnt(m_cnt, step, wrap);
            m_cnt   <= nc;
            m_busy  <= nbusy;
            m_pulse <= step;
            m_req   <= (nc == clr_val) ? en : '0;
            m_s0 <= edge_in; m_s1 <= m_s0; m_last <= m_s1;
        end
    end

    task automatic chk(input string t, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
        end
    endtask

    // One clock; outputs compared against the model at the falling edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag,  cnt,   m_cnt);
            chk("R3", pulse, m_pulse);
            chk("R6", req,   m_req);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5EED_0042));
        // R1: reset state
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", cnt, 0); chk("R1", pulse, 0); chk("R1", req, 0);
        ref_cnt = 8'd10; clr_val = 8'd200; rld_cnt = 8'd5; en = 4'b1011;
        rst = 1'b0;

        // R2 / R4: count up to the reference and stop there
        tag = "R2";
        step(15);
        chk("R4", cnt, 10); chk("R4", pulse, 0);

        // R5: stop at clear value below the reference; R6 lanes
        ref_cnt = 8'd100; clr_val = 8'd60; tag = "R5";
        step(60);
        chk("R5", cnt, 60); chk("R5", pulse, 0); chk("R6", req, 4'b1011);
        en = 4'b0100;
        step(2);
        chk("R6", req, 4'b0100);

        // R4: count above a lowered reference holds
        clr_val = 8'd200; ref_cnt = 8'd20; tag = "R4";
        step(5);
        chk("R4", cnt, 60); chk("R6", req, 0);

        // R7: edge ignored while reload count is nonzero
        edge_in = 1'b1; tag = "R7";
        step(6);
        chk("R7", cnt, 60); chk("R7", pulse, 0);
        edge_in = 1'b0;
        step(3);

        // R9 / R10: catch-up through the wrap point with an extra edge inside
        rld_cnt = '0; clr_val = 8'd58; ref_cnt = '0; tag = "R9";
        edge_in = 1'b1;
        step(3);
        chk("R9", cnt, 61); chk("R9", pulse, 1);
        edge_in = 1'b0;
        step(47);
        edge_in = 1'b1; tag = "R10";
        step(5);
        edge_in = 1'b0;
        step(45);
        chk("R9", pulse, 1); chk("R9", cnt, (60 + 98) % 256);
        step(156);
        chk("R9", cnt, 58);
        step(1);
        chk("R10", cnt, 1); chk("R9", pulse, 0);
        step(3);
        chk("R10", cnt, 1);

        // R8 / R11: edge on the clear value jumps to 1, then counting resumes
        ref_cnt = 8'd5; clr_val = 8'd5; tag = "R11";
        step(8);
        chk("R5", cnt, 5);
        edge_in = 1'b1; tag = "R8";
        step(3);
        chk("R8", cnt, 1); chk("R8", pulse, 0);
        edge_in = 1'b0; tag = "R11";
        step(1);
        chk("R11", cnt, 2);
        step(3);
        chk("R11", cnt, 5);

        // Random phase
        tag = "R2";
        for (int k = 0; k < 6000; k++) begin
            if ($urandom_range(0, 19) == 0) ref_cnt = W'($urandom);
            if ($urandom_range(0, 29) == 0) clr_val = W'($urandom);
            if ($urandom_range(0, 9) == 0)  rld_cnt = ($urandom_range(0, 2) == 0) ? W'($urandom) : '0;
            if ($urandom_range(0, 7) == 0)  edge_in = ~edge_in;
            if ($urandom_range(0, 15) == 0) en = N'($urandom);
            step(1);
        end

        // R1: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        chk("R1", cnt, 0); chk("R1", pulse, 0); chk("R1", req, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule